// File: doc/BRIEF.md
# Indirect Register Window Responder

This block sits on the device side of a register-level management port of a switch that holds several internal register sets: one per PHY, one per port and two global sets. Each access on the port carries a bus address, a register number, a write flag and write data; reads are answered combinationally on the same cycle. The register sets are modelled as RAM-backed banks of 32 sixteen-bit registers each. Unlisted device addresses read as all ones.

A strap input selects the addressing scheme. With the strap at zero the block answers on every bus address and uses that address as the internal device number. With any other strap value the block answers only on that one address and offers a two-register window. A master writes a command word naming an operation, a device and a register, then polls until busy clears. For a read it then fetches the result from the data register. For a write it places the data in the data register before issuing the command.

A command stays busy for a configurable number of cycles, so a master's polling loop is exercised. While busy is set, writes to the window are discarded.

Top module: `smi_window_target`

## Requirements
- R1: With strap at 0, every valid access sets bus_hit; a write stores data in, and a read returns, register bus_reg of the device numbered bus_addr.
- R2: With a non-zero strap, only accesses whose bus_addr equals the strap set bus_hit; any other access returns 0xFFFF and changes nothing.
- R3: In window mode register 0 is the command and register 1 the data. The command holds busy in bit 15, the clause-22 flag in bit 12, the opcode in bits 11:10 (2 read, 1 write), the device in bits 9:5 and the register in bits 4:0. A command write while idle always stores bits 14:0. It starts a command only if bits 15 and 12 are set and the opcode is 1 or 2.
- R4: Busy reads as 1 for exactly BUSY_CYCLES cycles after the edge that accepts a command, then reads 0.
- R5: When a read command completes, the data register holds the addressed internal register.
- R6: When a write command completes, the data register value is stored in the addressed internal register.
- R7: Device numbers 0..NUM_PORTS-1 are PHY sets, 0x10+p are port sets, and 0x1B and 0x1C are the two global sets. Both modes reach the same storage.
- R8: Any other device number reads 0xFFFF, and writes to it are discarded.
- R9: A command-register write while busy is set is ignored, including one on the edge that completes the command.
- R10: A data-register write while busy is set is ignored.
- R11: In window mode, registers 2..31 at the strap address read 0xFFFF and ignore writes.
- R12: After reset, busy, the command fields, the data register and all banks are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 5 | Strapped bus address; 0 selects direct mode |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Bus address of the access |
| bus_reg | input | 5 | Register number of the access |
| bus_wdata | input | 16 | Write data |
| bus_hit | output | 1 | The block claims this access |
| bus_rdata | output | 16 | Read data; 0xFFFF when not claimed |

## Verification
Two functions can meet on one edge: the completion of a running command, and a master write to the command or data register. The bench issues a command, waits exactly BUSY_CYCLES-1 cycles, and then drives a second command write. It repeats this with a data-register write, so that each write is captured on the completing edge. Both writes must be lost. The command fields read back must belong to the first command, and the data register must hold the first command's read result.

// File: rtl/smi_window_target.sv
module smi_window_target #(
  parameter int NUM_PORTS   = 7,
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  strap_addr,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [4:0]  bus_addr,
  input  logic [4:0]  bus_reg,
  input  logic [15:0] bus_wdata,
  output logic        bus_hit,
  output logic [15:0] bus_rdata
);
  localparam int NBANK = 2 * NUM_PORTS + 2;
  localparam int DEPTH = NBANK * 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(BUSY_CYCLES + 1);

  function automatic logic dev_ok(input logic [4:0] d);
    int v;
    v = int'(d);
    return (v < NUM_PORTS) || (v >= 16 && v < 16 + NUM_PORTS) || v == 27 || v == 28;
  endfunction

  function automatic logic [AW-1:0] dev_row(input logic [4:0] d, input logic [4:0] r);
    int v, b;
    v = int'(d);
    if (v < 16)      b = v;
    else if (v < 27) b = NUM_PORTS + v - 16;
    else             b = 2 * NUM_PORTS + v - 27;
    return AW'(b * 32 + int'(r));
  endfunction

  logic [15:0]   mem [DEPTH];
  logic [14:0]   cmd_q;
  logic [15:0]   data_q;
  logic [CW-1:0] cnt_q;

  wire busy    = (cnt_q != '0);
  wire direct  = (strap_addr == 5'd0);
  wire done    = (cnt_q == CW'(1));
  wire [4:0] c_dev = cmd_q[9:5];
  wire [4:0] c_reg = cmd_q[4:0];
  wire [1:0] c_op  = cmd_q[11:10];

  assign bus_hit = bus_valid && (direct || bus_addr == strap_addr);

  wire wr     = bus_hit && bus_write;
  wire wr_cmd = wr && !direct && bus_reg == 5'd0 && !busy;
  wire wr_dat = wr && !direct && bus_reg == 5'd1 && !busy;
  wire start  = wr_cmd && bus_wdata[15] && bus_wdata[12] &&
                (bus_wdata[11:10] == 2'd1 || bus_wdata[11:10] == 2'd2);

  wire [15:0] c_val = dev_ok(c_dev) ? mem[dev_row(c_dev, c_reg)] : 16'hFFFF;

  always_comb begin
    bus_rdata = 16'hFFFF;
    if (bus_hit) begin
      if (direct)
        bus_rdata = dev_ok(bus_addr) ? mem[dev_row(bus_addr, bus_reg)] : 16'hFFFF;
      else if (bus_reg == 5'd0)
        bus_rdata = {busy, cmd_q};
      else if (bus_reg == 5'd1)
        bus_rdata = data_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_cmd) cmd_q <= bus_wdata[14:0];
      if (start)
        cnt_q <= CW'(BUSY_CYCLES);
      else if (busy)
        cnt_q <= cnt_q - CW'(1);
      if (wr_dat) data_q <= bus_wdata;
      if (busy && done && c_op == 2'd2) data_q <= c_val;
      if (busy && done && c_op == 2'd1) begin
        if (dev_ok(c_dev)) mem[dev_row(c_dev, c_reg)] <= data_q;
      end else if (wr && direct && dev_ok(bus_addr)) begin
        mem[dev_row(bus_addr, bus_reg)] <= bus_wdata;
      end
    end
  end

  assert_direct_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (direct && bus_valid) |-> bus_hit);
  assert_foreign_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!direct && bus_addr != strap_addr) |-> (!bus_hit && bus_rdata == 16'hFFFF));
  assert_busy_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_valid && bus_write && bus_reg == 5'd0 && bus_wdata[15] && !direct));
  assert_cmd_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_hit && bus_write && bus_reg == 5'd0) |=> $stable(cmd_q));
  assert_data_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && bus_hit && bus_write && bus_reg == 5'd1) |=> $stable(data_q));
endmodule

// File: tb/smi_window_target_bench.sv
module smi_window_target_bench;
  localparam int B = 4;
  logic clk = 0, rst_n = 0;
  logic [4:0] strap_addr = 0, bus_addr = 0, bus_reg = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [15:0] bus_wdata = 0;
  logic bus_hit;
  logic [15:0] bus_rdata;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smi_window_target #(.NUM_PORTS(7), .BUSY_CYCLES(B)) u_smi_window_target (.*);

  // {addr, reg, wdata, expected}
  localparam logic [63:0] VEC [8] = '{
    {16'h00, 16'h02, 16'h1111, 16'h1111},
    {16'h06, 16'h1F, 16'h2222, 16'h2222},
    {16'h07, 16'h03, 16'h3333, 16'hFFFF},
    {16'h10, 16'h04, 16'h4444, 16'h4444},
    {16'h16, 16'h06, 16'h5555, 16'h5555},
    {16'h17, 16'h06, 16'h6666, 16'hFFFF},
    {16'h1B, 16'h1A, 16'h7777, 16'h7777},
    {16'h1C, 16'h18, 16'h8888, 16'h8888}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [4:0] a, input logic [4:0] r, input logic [15:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_reg = r; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic do_read(input logic [4:0] a, input logic [4:0] r,
                         output logic [15:0] d, output logic h);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_reg = r;
    #1 d = bus_rdata; h = bus_hit;
    bus_valid = 0;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    logic [15:0] d; logic h;
    n = 0;
    do begin
      do_read(5'd5, 5'd0, d, h);
      if (d[15]) n++;
    end while (d[15] && n < 50);
  endtask

  function automatic logic [15:0] cmd(input logic [1:0] op, input logic [4:0] dv, input logic [4:0] rg);
    return {1'b1, 2'b00, 1'b1, op, dv, rg};
  endfunction

  initial begin
    logic [15:0] d; logic h; int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    do_read(5'h10, 5'h04, d, h); check("R12 bank zero", d, 16'h0000);
    strap_addr = 5'd5;
    do_read(5'd5, 5'd0, d, h); check("R12 cmd zero", d, 16'h0000);
    do_read(5'd5, 5'd1, d, h); check("R12 data zero", d, 16'h0000);
    strap_addr = 5'd0;
    // R1 R7 R8 direct mode table
    for (int i = 0; i < 8; i++) do_write(VEC[i][52:48], VEC[i][36:32], VEC[i][31:16]);
    for (int i = 0; i < 8; i++) begin
      do_read(VEC[i][52:48], VEC[i][36:32], d, h);
      check("R1 direct hit", {15'd0, h}, 16'd1);
      check("R7/R8 direct map", d, VEC[i][15:0]);
    end
    // R2 multichip address filter
    strap_addr = 5'd5;
    do_read(5'd4, 5'd0, d, h);
    check("R2 no hit", {15'd0, h}, 16'd0);
    check("R2 float", d, 16'hFFFF);
    do_write(5'h10, 5'h04, 16'hDEAD);
    strap_addr = 5'd0;
    do_read(5'h10, 5'h04, d, h); check("R2 foreign write dropped", d, 16'h4444);
    strap_addr = 5'd5;
    // R11 other offsets
    do_write(5'd5, 5'd2, 16'h1234);
    do_read(5'd5, 5'd2, d, h); check("R11 offset 2", d, 16'hFFFF);
    do_read(5'd5, 5'd1, d, h); check("R11 data untouched", d, 16'h0000);
    // R3 invalid opcode stores fields, does not start
    do_write(5'd5, 5'd0, 16'h9C00 | 16'h0043);
    do_read(5'd5, 5'd0, d, h); check("R3 bad op no start", d, 16'h1C43);
    // R4 R5 read command through window
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h10, 5'h04));
    do_read(5'd5, 5'd0, d, h); check("R3 busy readback", d, cmd(2'd2, 5'h10, 5'h04));
    wait_idle(n);
    check("R4 busy length", 16'(n), 16'(B - 1));
    do_read(5'd5, 5'd1, d, h); check("R5 read result", d, 16'h4444);
    // R6 write command
    do_write(5'd5, 5'd1, 16'hABCD);
    do_write(5'd5, 5'd0, cmd(2'd1, 5'h1C, 5'h18));
    wait_idle(n);
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h1C, 5'h18));
    wait_idle(n);
    do_read(5'd5, 5'd1, d, h); check("R6 write then read", d, 16'hABCD);
    strap_addr = 5'd0;
    do_read(5'h1C, 5'h18, d, h); check("R7 shared storage", d, 16'hABCD);
    strap_addr = 5'd5;
    // R8 unimplemented via window
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h0F, 5'h01));
    wait_idle(n);
    do_read(5'd5, 5'd1, d, h); check("R8 window unimpl", d, 16'hFFFF);
    // R9 command while busy, mid-run
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h06, 5'h1F));
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h00, 5'h02));
    do_write(5'd5, 5'd1, 16'h0BAD);
    wait_idle(n);
    do_read(5'd5, 5'd0, d, h); check("R9 cmd kept", d, cmd(2'd2, 5'h06, 5'h1F) & 16'h7FFF);
    do_read(5'd5, 5'd1, d, h); check("R10 data kept", d, 16'h2222);
    // R9 collision on completing edge
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h16, 5'h06));
    repeat (B - 1) @(negedge clk);
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h1B, 5'h1A));
    do_read(5'd5, 5'd0, d, h); check("R9 completion collision", d, cmd(2'd2, 5'h16, 5'h06) & 16'h7FFF);
    do_read(5'd5, 5'd1, d, h); check("R5 collision result", d, 16'h5555);
    // R10 collision on completing edge
    do_write(5'd5, 5'd0, cmd(2'd2, 5'h1B, 5'h1A));
    repeat (B - 1) @(negedge clk);
    do_write(5'd5, 5'd1, 16'hF00D);
    do_read(5'd5, 5'd1, d, h); check("R10 completion collision", d, 16'h7777);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule